// File: doc/BRIEF.md
# Register List Stack Frame Sequencer

This block carries out the two halves of a procedure frame for a 32-bit processor. A build command saves a chosen subset of the twelve callee-saved registers r20..r31 onto the stack and then reserves an additional local area. A teardown command releases that local area, restores the same subset and can also name a register whose restored contents become the return jump target. One command therefore replaces a whole run of stores or loads plus stack pointer arithmetic.

The sequencer takes a 12-bit select mask, a 5-bit local-area size counted in words, an optional 5-bit jump register index and the current stack pointer. It reads and writes the register file through one read port and one write port, and it issues word-wide requests to memory one at a time, waiting for a ready handshake on each. When the final stack pointer is presented, a single-cycle done pulse marks completion. A busy output stays high for the whole operation, and commands that arrive during it are dropped.

Top module: `fsq_frame_seq`

## Requirements
- R1: After reset the block is idle: busy, done, mem_req, rf_we and jump_valid are all 0.
- R2: A build (cmd_build=1) visits the selected registers from r20 upward. For each one it first lowers the stack pointer by 4 and then writes that register's value to the new stack pointer (mem_we=1).
- R3: At the end of a build, sp_out equals the stack pointer left after the stores minus 4 times cmd_frame.
- R4: A teardown (cmd_build=0) first raises the stack pointer by 4 times cmd_frame. It then visits the selected registers from r31 downward, reading the word at the current stack pointer (mem_we=0), writing it to that register and then raising the stack pointer by 4.
- R5: At the end of a teardown, sp_out equals the stack pointer left after the last load.
- R6: On a teardown whose cmd_jreg is nonzero, jump_valid is 1 in the done cycle and jump_addr holds the contents of register cmd_jreg after all loads, including a value just restored. When cmd_jreg is 0, jump_valid stays 0.
- R7: Mask bit i selects register r(20+i), so bit 0 is r20 and bit 11 is r31.
- R8: Only one memory request is outstanding at a time. While mem_req is 1 and mem_ready is 0, mem_addr, mem_we and mem_wdata do not change.
- R9: done is a one-cycle pulse. busy is 1 from the cycle after acceptance through the done cycle. A command presented while busy is 1 is ignored and does not change the access sequence or the results.
- R10: A command with an empty mask makes no memory access. If the size is also zero, done rises in the cycle right after acceptance and sp_out equals sp_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_build | input | 1 | 1 = build frame, 0 = tear down frame |
| cmd_mask | input | 12 | Register select, bit i = r(20+i) |
| cmd_frame | input | 5 | Local area size in words |
| cmd_jreg | input | 5 | Teardown jump register index, 0 = no jump |
| sp_in | input | 32 | Stack pointer at command time |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Final stack pointer, valid with done |
| jump_valid | output | 1 | Teardown jump requested, with done |
| jump_addr | output | 32 | Jump target, valid with jump_valid |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Request completes this cycle |

## Verification
A corrupted pending mask or slot choice shows up on the very next memory handshake as a wrong address, a wrong store value or a wrong register index, because the reference model checks every transfer as it completes. A stack pointer that drifts shows up at once in mem_addr and again in sp_out at done. A fault in the jump path or in the completion logic shows up in the done cycle itself, or as activity on mem_req or done while the model expects the block to be idle.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int XLEN       = 32;
    localparam int NREG       = 12;
    localparam int BASE_REG   = 20;
    localparam int FRAME_W    = 5;
    localparam int RIDX_W     = 5;
    localparam int WORD_SHIFT = 2;
    localparam int SLOT_W     = $clog2(NREG);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FIN
    } fsq_state_e;

    typedef struct packed {
        logic                build;
        logic [FRAME_W-1:0]  frame;
        logic [RIDX_W-1:0]   jreg;
    } fsq_cmd_t;

    function automatic logic [XLEN-1:0] words_to_bytes(input logic [FRAME_W-1:0] w);
        return XLEN'(w) << WORD_SHIFT;
    endfunction

    function automatic logic [RIDX_W-1:0] slot_to_reg(input logic [SLOT_W-1:0] s);
        return RIDX_W'(BASE_REG) + RIDX_W'(s);
    endfunction
endpackage

// File: rtl/fsq_pick.sv
module fsq_pick #(
    parameter int N = 12,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic         high_first,
    output logic         found,
    output logic [W-1:0] idx
);
    logic [W-1:0] lo_idx;
    logic [W-1:0] hi_idx;

    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) hi_idx = W'(i);
        end
    end

    always_comb begin
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) lo_idx = W'(i);
        end
    end

    assign found = |vec;
    assign idx   = high_first ? hi_idx : lo_idx;
endmodule

// File: rtl/fsq_spunit.sv
module fsq_spunit
    import fsq_pkg::*;
(
    input  logic [XLEN-1:0]    sp_cur,
    input  logic [FRAME_W-1:0] frame,
    input  logic               build,
    output logic [XLEN-1:0]    sp_step,
    output logic [XLEN-1:0]    sp_frame,
    output logic [XLEN-1:0]    xfer_addr
);
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(1) << WORD_SHIFT;

    logic [XLEN-1:0] frame_bytes;

    assign frame_bytes = words_to_bytes(frame);
    assign sp_step     = build ? sp_cur - WORD_BYTES : sp_cur + WORD_BYTES;
    assign sp_frame    = build ? sp_cur - frame_bytes : sp_cur + frame_bytes;
    // stores pre-decrement, loads use the pointer before the increment
    assign xfer_addr   = build ? sp_step : sp_cur;
endmodule

// File: rtl/fsq_frame_seq.sv
module fsq_frame_seq
    import fsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_build,
    input  logic [NREG-1:0]    cmd_mask,
    input  logic [FRAME_W-1:0] cmd_frame,
    input  logic [RIDX_W-1:0]  cmd_jreg,
    input  logic [XLEN-1:0]    sp_in,
    output logic               busy,
    output logic               done,
    output logic [XLEN-1:0]    sp_out,
    output logic               jump_valid,
    output logic [XLEN-1:0]    jump_addr,
    output logic [RIDX_W-1:0]  rf_raddr,
    input  logic [XLEN-1:0]    rf_rdata,
    output logic               rf_we,
    output logic [RIDX_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]    rf_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [XLEN-1:0]    mem_addr,
    output logic [XLEN-1:0]    mem_wdata,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_ready
);
    fsq_state_e        state;
    fsq_cmd_t          cmd_r;
    logic [NREG-1:0]   pend;
    logic [XLEN-1:0]   sp_r;

    logic              idle;
    logic              sel_build;
    logic [FRAME_W-1:0] sel_frame;
    logic [XLEN-1:0]   sp_cur;
    logic [XLEN-1:0]   sp_step;
    logic [XLEN-1:0]   sp_frame;
    logic [XLEN-1:0]   xfer_addr;
    logic              pick_found;
    logic [SLOT_W-1:0] pick_idx;
    logic [NREG-1:0]   pend_after;
    logic              beat;

    assign idle      = (state == ST_IDLE);
    assign sel_build = idle ? cmd_build : cmd_r.build;
    assign sel_frame = idle ? cmd_frame : cmd_r.frame;
    assign sp_cur    = idle ? sp_in : sp_r;

    fsq_spunit u_sp (
        .sp_cur    (sp_cur),
        .frame     (sel_frame),
        .build     (sel_build),
        .sp_step   (sp_step),
        .sp_frame  (sp_frame),
        .xfer_addr (xfer_addr)
    );

    // build walks upward from r20, teardown walks downward from r31
    fsq_pick #(.N(NREG)) u_pick (
        .vec        (pend),
        .high_first (!cmd_r.build),
        .found      (pick_found),
        .idx        (pick_idx)
    );

    assign pend_after = pend & ~(NREG'(1) << pick_idx);
    assign beat       = (state == ST_XFER) && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd_r <= '0;
            pend  <= '0;
            sp_r  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        cmd_r <= '{build: cmd_build, frame: cmd_frame, jreg: cmd_jreg};
                        pend  <= cmd_mask;
                        sp_r  <= cmd_build ? sp_in : sp_frame;
                        state <= (|cmd_mask) ? ST_XFER : ST_FIN;
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        pend <= pend_after;
                        sp_r <= sp_step;
                        if (pend_after == '0) state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = !idle;
    assign done       = (state == ST_FIN);
    assign sp_out     = cmd_r.build ? sp_frame : sp_r;

    assign mem_req    = (state == ST_XFER) && pick_found;
    assign mem_we     = cmd_r.build;
    assign mem_addr   = xfer_addr;
    assign mem_wdata  = rf_rdata;

    assign rf_raddr   = done ? cmd_r.jreg : slot_to_reg(pick_idx);
    assign rf_we      = beat && !cmd_r.build;
    assign rf_waddr   = slot_to_reg(pick_idx);
    assign rf_wdata   = mem_rdata;

    assign jump_valid = done && !cmd_r.build && (cmd_r.jreg != '0);
    assign jump_addr  = jump_valid ? rf_rdata : '0;
endmodule

// File: rtl/fsq_frame_seq_chk.sv
module fsq_frame_seq_chk
    import fsq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              jump_valid,
    input logic              rf_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              mem_ready
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we && !done)); // R1

    AST_JUMP_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        jump_valid |-> done); // R6

    AST_RF_WRITE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_req && mem_ready && !mem_we)); // R4
endmodule

bind fsq_frame_seq fsq_frame_seq_chk u_chk (.*);

// File: tb/tb_fsq_frame_seq.sv
module tb_fsq_frame_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_build;
    logic [11:0] cmd_mask;
    logic [4:0]  cmd_frame;
    logic [4:0]  cmd_jreg;
    logic [31:0] sp_in;
    logic        busy, done, jump_valid;
    logic [31:0] sp_out, jump_addr;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;

    fsq_frame_seq dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench register file and memory
    logic [31:0] rf [32];
    logic [31:0] mem [logic [31:0]];
    assign rf_rdata = rf[rf_raddr];
    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_0000);
    endfunction

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model state
    logic [31:0] q_addr[$];
    logic        q_we[$];
    logic [31:0] q_data[$];
    logic [4:0]  q_reg[$];
    logic [31:0] exp_sp;
    logic        exp_jv;
    logic [31:0] exp_ja;
    bit          exp_active = 0;
    bit          exp_build;

    task automatic model(input bit b, input logic [11:0] m, input logic [4:0] f,
                         input logic [4:0] j, input logic [31:0] sp);
        logic [31:0] s;
        logic [31:0] shadow [32];
        for (int k = 0; k < 32; k++) shadow[k] = rf[k];
        s = sp;
        exp_build = b;
        if (b) begin
            for (int i = 0; i < 12; i++) if (m[i]) begin
                s = s - 32'd4;
                q_addr.push_back(s); q_we.push_back(1'b1);
                q_data.push_back(rf[20+i]); q_reg.push_back(5'(20+i));
            end
            s = s - {25'd0, f, 2'b00};
            exp_jv = 1'b0; exp_ja = '0;
        end else begin
            s = s + {25'd0, f, 2'b00};
            for (int i = 11; i >= 0; i--) if (m[i]) begin
                q_addr.push_back(s); q_we.push_back(1'b0);
                q_data.push_back(memval(s)); q_reg.push_back(5'(20+i));
                shadow[20+i] = memval(s);
                s = s + 32'd4;
            end
            exp_jv = (j != 0);
            exp_ja = (j != 0) ? shadow[j] : '0;
        end
        exp_sp = s;
        exp_active = 1;
    endtask

    // memory responder with varying latency, checks each transfer
    int wait_cnt = 0;
    int lat_seq  = 1;
    initial begin
        mem_ready = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) mem_ready = 0;
            else if (mem_req) begin
                if (wait_cnt != 0) wait_cnt--;
                else if (q_addr.size() == 0) begin
                    chk(0, "R9 unexpected access", mem_addr, 32'h0);
                    mem_ready = 1;
                end else begin
                    logic [31:0] ea, ed; logic ew; logic [4:0] er;
                    ea = q_addr.pop_front(); ew = q_we.pop_front();
                    ed = q_data.pop_front(); er = q_reg.pop_front();
                    chk(mem_addr == ea, exp_build ? "R2 R7 store address" : "R4 R7 load address", mem_addr, ea);
                    chk(mem_we == ew, "R2 R4 direction", {31'd0, mem_we}, {31'd0, ew});
                    if (ew) begin
                        chk(mem_wdata == ed, "R2 R7 store data", mem_wdata, ed);
                        mem[mem_addr] = mem_wdata;
                        mem_ready = 1;
                    end else begin
                        mem_rdata = memval(mem_addr);
                        mem_ready = 1;
                        #1;
                        chk(rf_we && rf_waddr == er, "R4 R7 restore register", {27'd0, rf_waddr}, {27'd0, er});
                        chk(rf_wdata == ed, "R4 restore data", rf_wdata, ed);
                    end
                    wait_cnt = lat_seq;
                    lat_seq  = (lat_seq + 1) % 3;
                end
            end
        end
    end

    // completion and idle monitor, every clock
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done) begin
                    chk(exp_active, "R9 spurious done", 32'd1, 32'd0);
                    chk(sp_out == exp_sp, exp_build ? "R3 final sp" : "R5 final sp", sp_out, exp_sp);
                    chk(jump_valid == exp_jv, "R6 jump valid", {31'd0, jump_valid}, {31'd0, exp_jv});
                    if (exp_jv) chk(jump_addr == exp_ja, "R6 jump target", jump_addr, exp_ja);
                    chk(q_addr.size() == 0, "R9 accesses missing", q_addr.size(), 32'd0);
                    exp_active = 0;
                end else if (!exp_active) begin
                    chk(!mem_req && !busy, "R9 idle quiet", {30'd0, mem_req, busy}, 32'd0);
                end
            end
        end
    end

    task automatic issue(input bit b, input logic [11:0] m, input logic [4:0] f,
                         input logic [4:0] j, input logic [31:0] sp);
        @(negedge clk);
        model(b, m, f, j, sp);
        cmd_build = b; cmd_mask = m; cmd_frame = f; cmd_jreg = j; sp_in = sp;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_idle();
        while (exp_active) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1; cmd_valid = 0; cmd_build = 0; cmd_mask = '0;
        cmd_frame = '0; cmd_jreg = '0; sp_in = '0;
        for (int k = 0; k < 32; k++) rf[k] = 32'h1000_0000 + k * 32'h111;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mem_req && !rf_we && !jump_valid, "R1 reset idle",
            {27'd0, busy, done, mem_req, rf_we, jump_valid}, 32'd0);

        // R2 R3 sparse build
        issue(1, 12'b0000_0000_0101, 5'd3, 5'd0, 32'h0000_1000);
        wait_idle();
        // R7 only the top register
        issue(1, 12'b1000_0000_0000, 5'd0, 5'd0, 32'h0000_2000);
        wait_idle();
        // R4 R5 R6 teardown of the sparse frame, jump through r22 which is restored
        rf[22] = 32'hDEAD_0001;
        issue(0, 12'b0000_0000_0101, 5'd3, 5'd22, 32'h0000_1000 - 32'd8 - 32'd12);
        wait_idle();
        // R2 R3 full mask, largest frame
        issue(1, 12'hFFF, 5'd31, 5'd0, 32'h0000_3000);
        wait_idle();
        // R4 R6 full teardown, no jump
        for (int k = 20; k < 32; k++) rf[k] = 32'hBAD0_0000 + k;
        issue(0, 12'hFFF, 5'd31, 5'd0, 32'h0000_3000 - 32'd48 - 32'd124);
        wait_idle();
        // R6 jump through register outside the list
        issue(0, 12'b0110_0000_0000, 5'd2, 5'd5, 32'h0000_4000);
        wait_idle();
        // R10 empty mask, zero size: done right after acceptance
        issue(1, 12'h000, 5'd0, 5'd0, 32'h0000_5550);
        chk(done && sp_out == 32'h0000_5550, "R10 fast build", sp_out, 32'h0000_5550);
        wait_idle();
        issue(0, 12'h000, 5'd0, 5'd0, 32'h0000_6660);
        chk(done && sp_out == 32'h0000_6660, "R10 fast teardown", sp_out, 32'h0000_6660);
        wait_idle();
        // R10 empty mask with size: only pointer arithmetic
        issue(1, 12'h000, 5'd7, 5'd0, 32'h0000_7000);
        wait_idle();
        issue(0, 12'h000, 5'd7, 5'd9, 32'h0000_7000);
        wait_idle();
        // R9 commands while busy are dropped
        issue(1, 12'b0011_1100_0011, 5'd1, 5'd0, 32'h0000_8000);
        repeat (2) @(negedge clk);
        cmd_build = 0; cmd_mask = 12'hFFF; cmd_frame = 5'd9; cmd_jreg = 5'd3; sp_in = 32'h1234_5678;
        cmd_valid = 1;
        repeat (3) @(negedge clk);
        cmd_valid = 0;
        wait_idle();
        chk(!busy, "R9 idle after dropped command", {31'd0, busy}, 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule